// File: doc/BRIEF.md
# Time-Shared Multi-Bank Sub-Window Address FIFO

This block carries the addresses of accepted sub-windows from one classifier stage to the next. It holds four logical FIFO banks grouped as two ping-pong pairs. Pair 0 links the first stage to the second, and pair 1 links the second stage to the third. In each pair, one bank takes pushes from the producing stage while its partner is drained by the consuming stage. A swap at a frame boundary exchanges the two roles.

All four banks live in one single-port memory. Each bank owns a fixed quarter of it, addressed as {bank, local pointer}. The memory runs on the fast clock `clk_i`. The FIFO side advances once per slow cycle of `RATIO` fast cycles, and `frame_o` marks the last fast cycle of each slow cycle. A round-robin scheduler gives bank k fast slot k of every slow cycle, so each bank gets one memory access per slow cycle.

Clients drive requests right after a slow edge and hold them for the whole slow cycle. A pending push or pop is carried out in the slot of the addressed bank. All flags and read data are settled by the following slow edge.

Top module: `swin_fifo_bank`

## Requirements
- R1: After reset, every bank is empty. `empty_o` is 2'b11, and `full_o`, `ovf_o`, `udf_o`, `wr_sel_o`, `pop_data_o` and `frame_o` are all zero.
- R2: `frame_o` is high for exactly one fast cycle in every `RATIO` fast cycles.
- R3: In each pair, words pushed into the writable bank are later popped from that same bank, once it is readable, in push order. A word popped in a slow cycle appears on `pop_data_o` after the slow edge that ends that cycle. It stays there until the next successful pop on that pair.
- R4: Each bank uses the memory only in its own slot, and no more than one bank is granted at any time. Traffic on one pair never changes the flags or data of the other pair.
- R5: After each slow edge, `full_o[p]` is 1 exactly when the writable bank of pair p holds `DEPTH` words. `empty_o[p]` is 1 exactly when the readable bank of pair p holds no unread word.
- R6: A push to a full writable bank is dropped and does not change the stored words. It sets `ovf_o[p]`, which stays set until reset.
- R7: A pop from an empty readable bank is dropped and leaves `pop_data_o[p]` unchanged. It sets `udf_o[p]`, which stays set until reset.
- R8: A slow cycle with `swap_i[p]` high toggles `wr_sel_o[p]`. `wr_sel_o[p]` is 0 when bank 2p is the writable bank and 1 when bank 2p+1 is. The bank that becomes writable is emptied, and any words left unread in it are discarded. `wr_sel_o` changes only at a slow edge.
- R9: A push or pop issued in the same slow cycle as a swap uses the roles that held before the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_o | output | 1 | High in the last fast cycle of each slow cycle |
| push_i | input | 2 | Push request per pair, held for the whole slow cycle |
| push_data_i | input | 2x20 | Address word pushed, one per pair |
| pop_i | input | 2 | Pop request per pair |
| pop_data_o | output | 2x20 | Most recently popped word per pair |
| swap_i | input | 2 | Swap the write/read roles of a pair at the slow edge |
| full_o | output | 2 | Writable bank of the pair is full |
| empty_o | output | 2 | Readable bank of the pair is empty |
| wr_sel_o | output | 2 | Which bank of the pair is writable (0: even, 1: odd) |
| ovf_o | output | 2 | Sticky overflow flag per pair |
| udf_o | output | 2 | Sticky underflow flag per pair |

## Verification
A wrong write pointer or a mis-decoded quarter address shows up at the pair's `pop_data_o`. It appears on the first pop that reaches the damaged entry, which can be up to `DEPTH` slow cycles after the fault. It can also show in the other pair's data, because the banks share the memory. A pointer that is not cleared on a swap is seen one slow edge later, as a wrong `empty_o` or `full_o` on the newly writable bank. A slot scheduler that skips or doubles a slot corrupts flags within one slow cycle. The bench compares every output after every slow edge against a model of the four banks, so each of these faults is reported on the slow cycle where it first becomes visible.

// File: rtl/swin_fifo_pkg.sv
package swin_fifo_pkg;
  localparam int NUM_PAIRS = 2;
  localparam int NUM_BANKS = 2 * NUM_PAIRS;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  function automatic int pair_of(input int bank);
    return bank / 2;
  endfunction
endpackage

// File: rtl/swin_slot_sched.sv
module swin_slot_sched #(
  parameter int RATIO     = 4,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output logic [NUM_BANKS-1:0] grant_o,
  output logic                 frame_o
);
  localparam int SLOT_W = $clog2(RATIO);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            slot_q <= '0;
    else if (slot_q == SLOT_W'(RATIO - 1))  slot_q <= '0;
    else                                    slot_q <= slot_q + 1'b1;
  end

  // slot k belongs to bank k; slots beyond the bank count stay idle
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_grant
    assign grant_o[k] = (slot_q == SLOT_W'(k));
  end

  assign frame_o = (slot_q == SLOT_W'(RATIO - 1));
endmodule

// File: rtl/swin_bank_ctrl.sv
module swin_bank_ctrl #(
  parameter int DEPTH = 204,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grant_i,
  input  logic             writable_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             clear_i,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [PTR_W-1:0] laddr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_set_o,
  output logic             udf_set_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] wptr_q, rptr_q;
  logic             wr_try, rd_try;

  assign full_o  = (wptr_q == CNT_W'(DEPTH));
  assign empty_o = (rptr_q == wptr_q);

  assign wr_try = grant_i &  writable_i & push_i;
  assign rd_try = grant_i & ~writable_i & pop_i;

  assign mem_we_o  = wr_try & ~full_o;
  assign mem_re_o  = rd_try & ~empty_o;
  assign ovf_set_o = wr_try &  full_o;
  assign udf_set_o = rd_try &  empty_o;

  assign laddr_o = writable_i ? wptr_q[PTR_W-1:0] : rptr_q[PTR_W-1:0];

  // a bank is only ever written or read between clears, so pointers never wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (mem_we_o) begin
      wptr_q <= wptr_q + 1'b1;
    end else if (mem_re_o) begin
      rptr_q <= rptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/swin_sp_mem.sv
module swin_sp_mem #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/swin_fifo_bank.sv
module swin_fifo_bank
  import swin_fifo_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int DEPTH  = 204,
  parameter int RATIO  = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  output logic                              frame_o,
  input  logic [NUM_PAIRS-1:0]              push_i,
  input  logic [NUM_PAIRS-1:0][WORD_W-1:0]  push_data_i,
  input  logic [NUM_PAIRS-1:0]              pop_i,
  output logic [NUM_PAIRS-1:0][WORD_W-1:0]  pop_data_o,
  input  logic [NUM_PAIRS-1:0]              swap_i,
  output logic [NUM_PAIRS-1:0]              full_o,
  output logic [NUM_PAIRS-1:0]              empty_o,
  output logic [NUM_PAIRS-1:0]              wr_sel_o,
  output logic [NUM_PAIRS-1:0]              ovf_o,
  output logic [NUM_PAIRS-1:0]              udf_o
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int MEM_AW = BANK_W + PTR_W;

  logic [NUM_BANKS-1:0] grant;
  logic [NUM_BANKS-1:0] bank_we, bank_re, bank_full, bank_empty;
  logic [NUM_BANKS-1:0] ovf_set, udf_set;
  logic [PTR_W-1:0]     bank_laddr [NUM_BANKS];

  logic [NUM_PAIRS-1:0]             wsel_q, ovf_q, udf_q;
  logic [NUM_PAIRS-1:0][WORD_W-1:0] pop_data_q;

  logic [MEM_AW-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic              mem_we;

  swin_slot_sched #(
    .RATIO     (RATIO),
    .NUM_BANKS (NUM_BANKS)
  ) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grant_o (grant),
    .frame_o (frame_o)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    localparam int P = pair_of(k);
    logic writable, clear;

    assign writable = (wsel_q[P] == 1'(k % 2));
    // the bank leaving the read role is emptied as it becomes writable
    assign clear    = frame_o & swap_i[P] & ~writable;

    swin_bank_ctrl #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W)
    ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .grant_i    (grant[k]),
      .writable_i (writable),
      .push_i     (push_i[P]),
      .pop_i      (pop_i[P]),
      .clear_i    (clear),
      .mem_we_o   (bank_we[k]),
      .mem_re_o   (bank_re[k]),
      .laddr_o    (bank_laddr[k]),
      .full_o     (bank_full[k]),
      .empty_o    (bank_empty[k]),
      .ovf_set_o  (ovf_set[k]),
      .udf_set_o  (udf_set[k])
    );
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (grant[k]) begin
        mem_addr  = {BANK_W'(k), bank_laddr[k]};
        mem_wdata = push_data_i[pair_of(k)];
      end
    end
  end

  assign mem_we = |bank_we;

  swin_sp_mem #(
    .WORD_W (WORD_W),
    .ADDR_W (MEM_AW)
  ) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsel_q     <= '0;
      ovf_q      <= '0;
      udf_q      <= '0;
      pop_data_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (frame_o && swap_i[p]) wsel_q[p] <= ~wsel_q[p];
        if (ovf_set[2*p] || ovf_set[2*p+1]) ovf_q[p] <= 1'b1;
        if (udf_set[2*p] || udf_set[2*p+1]) udf_q[p] <= 1'b1;
      end
      for (int k = 0; k < NUM_BANKS; k++) begin
        if (bank_re[k]) pop_data_q[pair_of(k)] <= mem_rdata;
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_flags
    assign full_o[p]  = wsel_q[p] ? bank_full[2*p+1]  : bank_full[2*p];
    assign empty_o[p] = wsel_q[p] ? bank_empty[2*p]   : bank_empty[2*p+1];
  end

  assign wr_sel_o   = wsel_q;
  assign ovf_o      = ovf_q;
  assign udf_o      = udf_q;
  assign pop_data_o = pop_data_q;
endmodule

// File: rtl/swin_fifo_bank_chk.sv
module swin_fifo_bank_chk
  import swin_fifo_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frame_i,
  input logic [NUM_BANKS-1:0] grant_i,
  input logic [NUM_PAIRS-1:0] ovf_i,
  input logic [NUM_PAIRS-1:0] udf_i,
  input logic [NUM_PAIRS-1:0] wr_sel_i
);
  AST_FRAME_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> !frame_i); // R2

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i)); // R4

  AST_ROLE_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(wr_sel_i)); // R8

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[p] |=> ovf_i[p]); // R6

    AST_NO_UNDERFLOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      udf_i[p] |=> udf_i[p]); // R7
  end
endmodule

bind swin_fifo_bank swin_fifo_bank_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frame_i  (frame_o),
  .grant_i  (grant),
  .ovf_i    (ovf_o),
  .udf_i    (udf_o),
  .wr_sel_i (wr_sel_o)
);

// File: tb/tb_swin_fifo_bank.sv
`timescale 1ns/1ps
module tb_swin_fifo_bank;
  localparam int W = 20;
  localparam int D = 204;
  localparam int R = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_o;
  logic [1:0] push_i = '0, pop_i = '0, swap_i = '0;
  logic [1:0][W-1:0] push_data_i = '0;
  logic [1:0][W-1:0] pop_data_o;
  logic [1:0] full_o, empty_o, wr_sel_o, ovf_o, udf_o;

  always #2.5 clk_i = ~clk_i;

  swin_fifo_bank #(.WORD_W(W), .DEPTH(D), .RATIO(R)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_o(frame_o),
    .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
    .pop_data_o(pop_data_o), .swap_i(swap_i), .full_o(full_o),
    .empty_o(empty_o), .wr_sel_o(wr_sel_o), .ovf_o(ovf_o), .udf_o(udf_o)
  );

  // model of the four banks
  logic [W-1:0] mm [4][D];
  int  wp [4];
  int  rp [4];
  bit  ws [2];
  bit  eovf [2];
  bit  eudf [2];
  logic [W-1:0] edat [2];

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  function automatic void model_step(input bit [1:0] pu, po, sw, input logic [1:0][W-1:0] d);
    for (int p = 0; p < 2; p++) begin
      int wb, rb;
      wb = 2*p + int'(ws[p]);
      rb = 2*p + int'(!ws[p]);
      if (pu[p]) begin
        if (wp[wb] == D) eovf[p] = 1;
        else begin mm[wb][wp[wb]] = d[p]; wp[wb]++; end
      end
      if (po[p]) begin
        if (rp[rb] == wp[rb]) eudf[p] = 1;
        else begin edat[p] = mm[rb][rp[rb]]; rp[rb]++; end
      end
      if (sw[p]) begin
        ws[p] = !ws[p];
        wp[rb] = 0;
        rp[rb] = 0;
      end
    end
  endfunction

  // wait until just after the slow edge that ends the current slow cycle
  task automatic to_edge();
    do @(negedge clk_i); while (!frame_o);
    @(negedge clk_i);
  endtask

  task automatic compare_all();
    for (int p = 0; p < 2; p++) begin
      int wb, rb;
      wb = 2*p + int'(ws[p]);
      rb = 2*p + int'(!ws[p]);
      chk(full_o[p] == (wp[wb] == D), $sformatf("R5 full pair%0d", p), 32'(full_o[p]), 32'(wp[wb] == D));
      chk(empty_o[p] == (rp[rb] == wp[rb]), $sformatf("R5 empty pair%0d", p), 32'(empty_o[p]), 32'(rp[rb] == wp[rb]));
      chk(wr_sel_o[p] == ws[p], $sformatf("R8 wr_sel pair%0d", p), 32'(wr_sel_o[p]), 32'(ws[p]));
      chk(ovf_o[p] == eovf[p], $sformatf("R6 ovf pair%0d", p), 32'(ovf_o[p]), 32'(eovf[p]));
      chk(udf_o[p] == eudf[p], $sformatf("R7 udf pair%0d", p), 32'(udf_o[p]), 32'(eudf[p]));
      chk(pop_data_o[p] == edat[p], $sformatf("R3 pop_data pair%0d", p), 32'(pop_data_o[p]), 32'(edat[p]));
    end
  endtask

  task automatic slow(input bit [1:0] pu, po, sw, input logic [W-1:0] d0, d1);
    push_i = pu; pop_i = po; swap_i = sw;
    push_data_i[0] = d0; push_data_i[1] = d1;
    model_step(pu, po, sw, push_data_i);
    to_edge();
    push_i = '0; pop_i = '0; swap_i = '0;
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int b = 0; b < 4; b++) begin wp[b] = 0; rp[b] = 0; end
    for (int p = 0; p < 2; p++) begin ws[p] = 0; eovf[p] = 0; eudf[p] = 0; edat[p] = '0; end

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(empty_o == 2'b11, "R1 empty", 32'(empty_o), 32'h3);
    chk(full_o == 2'b00 && ovf_o == 2'b00 && udf_o == 2'b00, "R1 flags",
        {26'd0, full_o, ovf_o, udf_o}, 32'h0);
    chk(wr_sel_o == 2'b00 && pop_data_o == '0, "R1 role/data", 32'(wr_sel_o), 32'h0);
    chk(frame_o == 1'b0, "R1 frame", 32'(frame_o), 32'h0);

    // R2 slow-cycle period
    begin
      int last, cyc;
      last = -1; cyc = 0;
      for (int n = 0; n < 4 * R + 2; n++) begin
        @(negedge clk_i);
        cyc++;
        if (frame_o) begin
          if (last >= 0) chk(cyc - last == R, "R2 frame period", 32'(cyc - last), 32'(R));
          last = cyc;
        end
      end
    end

    to_edge();

    // R3/R9: three pushes on pair 0, swap in the same cycle as the last push
    slow(2'b01, 2'b00, 2'b00, 20'h1_1111, 20'h0);
    slow(2'b01, 2'b00, 2'b00, 20'h2_2222, 20'h0);
    slow(2'b01, 2'b00, 2'b01, 20'h3_3333, 20'h0);
    slow(2'b00, 2'b01, 2'b00, 20'h0, 20'h0);
    chk(pop_data_o[0] == 20'h1_1111, "R3 first pop", 32'(pop_data_o[0]), 32'h11111);
    slow(2'b00, 2'b01, 2'b00, 20'h0, 20'h0);
    slow(2'b00, 2'b01, 2'b00, 20'h0, 20'h0);
    chk(pop_data_o[0] == 20'h3_3333, "R9 push with swap kept", 32'(pop_data_o[0]), 32'h33333);
    chk(empty_o[0] == 1'b1, "R5 drained", 32'(empty_o[0]), 32'h1);
    // R7: pop on empty keeps data, sets flag
    slow(2'b00, 2'b01, 2'b00, 20'h0, 20'h0);
    chk(udf_o[0] == 1'b1 && pop_data_o[0] == 20'h3_3333, "R7 empty pop", 32'(pop_data_o[0]), 32'h33333);

    // R4/R6: fill pair 1, pair 0 untouched
    for (int i = 0; i < D; i++) slow(2'b10, 2'b00, 2'b00, 20'h0, W'(32'h5_0000 + i));
    chk(full_o[1] == 1'b1, "R5 full after DEPTH", 32'(full_o[1]), 32'h1);
    chk(full_o[0] == 1'b0 && ovf_o[0] == 1'b0, "R4 pair0 isolated", 32'(full_o[0]), 32'h0);
    slow(2'b10, 2'b00, 2'b00, 20'h0, 20'hF_FFFF);
    chk(ovf_o[1] == 1'b1, "R6 overflow flag", 32'(ovf_o[1]), 32'h1);
    slow(2'b00, 2'b00, 2'b10, 20'h0, 20'h0);
    for (int i = 0; i < D; i++) slow(2'b00, 2'b10, 2'b00, 20'h0, 20'h0);
    chk(pop_data_o[1] == W'(32'h5_0000 + D - 1), "R6 last word intact", 32'(pop_data_o[1]), 32'h50000 + D - 1);

    // R8: leftovers are discarded when a bank becomes writable again
    slow(2'b01, 2'b00, 2'b00, 20'hA_0001, 20'h0);
    slow(2'b01, 2'b00, 2'b00, 20'hA_0002, 20'h0);
    slow(2'b01, 2'b00, 2'b01, 20'hA_0003, 20'h0);
    slow(2'b00, 2'b01, 2'b00, 20'h0, 20'h0);
    slow(2'b00, 2'b00, 2'b01, 20'h0, 20'h0);
    slow(2'b01, 2'b00, 2'b00, 20'hB_0001, 20'h0);
    slow(2'b00, 2'b00, 2'b01, 20'h0, 20'h0);
    slow(2'b00, 2'b01, 2'b00, 20'h0, 20'h0);
    chk(pop_data_o[0] == 20'hB_0001, "R8 new words only", 32'(pop_data_o[0]), 32'hB0001);
    chk(empty_o[0] == 1'b1, "R8 leftovers gone", 32'(empty_o[0]), 32'h1);

    // random traffic against the model
    for (int n = 0; n < 2500; n++) begin
      bit [1:0] pu, po, sw;
      for (int p = 0; p < 2; p++) begin
        pu[p] = ($urandom % 4) != 0;
        po[p] = ($urandom % 3) == 0;
        sw[p] = ($urandom % 60) == 0;
      end
      slow(pu, po, sw, W'($urandom), W'($urandom));
    end

    finish_run();
  end
endmodule